// File: doc/BRIEF.md
# Peripheral Clock Ratio Controller with Deferred Standby Change

This block sets the rate of the peripheral clock enable and the multiplication setting that a clock generator would use. Software writes a 6-bit ratio word through a plain write strobe. Bits [2:0] of the word are the division code and bits [5:3] are the multiplication code. A second strobe writes two control bits: a standby-enable bit and a change-on-wake bit. A third strobe loads the length of the oscillator settling wait.

When the change-on-wake bit is clear, a ratio write becomes active at once. When the bit is set, the write is only held as a pending value. In that mode the three mode pins are also captured when software standby begins. Standby begins when a sleep request arrives while the standby-enable bit is set. A wake interrupt ends the standby state and starts the settling counter. When that counter reaches zero, the pending ratio and the pending mode become active together, and the clock enable starts again.

The divider turns the active division code into a one-cycle enable pulse. A new code is taken up only at the divider's terminal count, so no enable interval is ever cut short.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are: active division code 3'b011, active multiplication code 3'b001, active mode equal to the mode pins sampled in reset, and halted low.
- R2: The ratio word uses bits [2:0] as the division code and bits [5:3] as the multiplication code. When the change-on-wake bit (control bit 1) is 0, a ratio write shows on the active outputs in the cycle after the strobe.
- R3: When the change-on-wake bit is 1, a ratio write leaves the active outputs unchanged. The word is kept as the pending value.
- R4: A sleep request in the running state moves the block into standby when the standby-enable bit (control bit 0) is 1. From the next cycle, halted is high and pclk_en is low. A sleep request while that bit is 0 is ignored.
- R5: The mode pins are captured at standby entry only when the change-on-wake bit is 1. The active mode changes only when a standby exit completes.
- R6: A wake interrupt during standby loads the settling counter with the stored settle value L. After the cycle that sampled the wake, halted stays high for exactly L+1 cycles. A wake interrupt while running is ignored.
- R7: When the settle wait ends, the active ratio and mode take the pending values, and no second write is needed.
- R8: Division codes 0 to 7 give pclk_en as a one-cycle pulse every 1, 2, 3, 4, 6, 8, 12 or 16 cycles.
- R9: A change of the division code takes effect only after the current enable interval completes at its old length.
- R10: pclk_en is high in the first cycle in which halted is low after a standby exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mode_pins | input | 3 | Clock mode pins |
| frq_wr | input | 1 | Ratio word write strobe |
| frq_wdata | input | 6 | Ratio word: [5:3] multiplication code, [2:0] division code |
| stb_wr | input | 1 | Control write strobe |
| stb_wdata | input | 2 | [1] change-on-wake, [0] standby enable |
| settle_wr | input | 1 | Settle length write strobe |
| settle_wdata | input | 8 | Settle length L |
| sleep_req | input | 1 | Sleep request |
| wake_irq | input | 1 | Wake interrupt |
| pclk_en | output | 1 | Divided clock enable pulse |
| active_mul | output | 3 | Active multiplication code |
| active_div | output | 3 | Active division code |
| active_mode | output | 3 | Active clock mode |
| halted | output | 1 | High in standby and during settling |

## Verification
A wrong pending or active register shows on the active outputs in the cycle after the write or after the settle end. A corrupted divider count changes the spacing of pclk_en within at most sixteen cycles. A wrong settle counter moves the cycle in which halted falls, so the directed settle check catches it at once. Each cycle, a reference model in the bench is compared against every output, so a hidden state error shows at the first cycle in which it reaches a port.

// File: rtl/crc_pkg.sv
// Package: shared types and the division code table for the clock ratio controller.
// Assumes the division code is 3 bits wide and the largest factor is 16.
package crc_pkg;

    localparam int CODE_W     = 3;
    localparam int MAX_FACTOR = 16;
    localparam int FACT_W     = $clog2(MAX_FACTOR) + 1;
    localparam int DCNT_W     = $clog2(MAX_FACTOR);

    // Power-management states of the controller.
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STBY   = 2'd1,
        ST_SETTLE = 2'd2
    } pm_state_t;

    // Ratio word as written by software.
    typedef struct packed {
        logic [CODE_W-1:0] mul;
        logic [CODE_W-1:0] div;
    } ratio_t;

    // Map a division code to its divide factor.
    function automatic logic [FACT_W-1:0] div_factor(input logic [CODE_W-1:0] code);
        logic [FACT_W-1:0] f;
        case (code)
            3'd0:    f = FACT_W'(1);
            3'd1:    f = FACT_W'(2);
            3'd2:    f = FACT_W'(3);
            3'd3:    f = FACT_W'(4);
            3'd4:    f = FACT_W'(6);
            3'd5:    f = FACT_W'(8);
            3'd6:    f = FACT_W'(12);
            default: f = FACT_W'(16);
        endcase
        return f;
    endfunction

endpackage

// File: rtl/crc_regs.sv
// Module: register file of the clock ratio controller. It holds the control
// bits, the pending and active ratio words, and the pending and active mode.
// Assumes enter_i and apply_i are single-cycle pulses from the standby FSM.
module crc_regs
    import crc_pkg::*;
#(
    parameter int          MODE_W    = 3,
    parameter logic [2:0]  MUL_RESET = 3'b001,
    parameter logic [2:0]  DIV_RESET = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              frq_wr,
    input  ratio_t            frq_wdata,
    input  logic              stb_wr,
    input  logic [1:0]        stb_wdata,
    input  logic              enter_i,
    input  logic              apply_i,
    output logic              stby_o,
    output logic              mdchg_o,
    output ratio_t            active_o,
    output logic [MODE_W-1:0] active_mode_o
);

    localparam ratio_t RATIO_RESET = '{mul: MUL_RESET, div: DIV_RESET};

    logic              stby_q, mdchg_q;
    ratio_t            pend_q, active_q;
    logic [MODE_W-1:0] pend_mode_q, active_mode_q;

    // Control bits: standby enable and change-on-wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stby_q  <= 1'b0;
            mdchg_q <= 1'b0;
        end else if (stb_wr) begin
            stby_q  <= stb_wdata[0];
            mdchg_q <= stb_wdata[1];
        end
    end

    // Pending ratio: every write is kept for the next standby exit.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= RATIO_RESET;
        else if (frq_wr) pend_q <= frq_wdata;
    end

    // Active ratio: set at once when no change is deferred, else at standby exit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active_q <= RATIO_RESET;
        else if (frq_wr && !mdchg_q)  active_q <= frq_wdata;
        else if (apply_i)             active_q <= pend_q;
    end

    // Pending mode: pins taken at reset, and at standby entry when a change is deferred.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_mode_q <= mode_pins;
        else if (enter_i && mdchg_q) pend_mode_q <= mode_pins;
    end

    // Active mode: pins taken at reset, then updated only at standby exit.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_mode_q <= mode_pins;
        else if (apply_i) active_mode_q <= pend_mode_q;
    end

    assign stby_o        = stby_q;
    assign mdchg_o       = mdchg_q;
    assign active_o      = active_q;
    assign active_mode_o = active_mode_q;

    // R2: a write with no deferral shows on the active ratio in the next cycle.
    a_r2_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
        frq_wr && !mdchg_q |=> active_q == $past(frq_wdata));

    // R3: a deferred write does not disturb the active ratio.
    a_r3_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        frq_wr && mdchg_q && !apply_i |=> $stable(active_q));

    // R5: the active mode moves only on a standby exit.
    a_r5_mode_on_exit_only: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(active_mode_q));

endmodule

// File: rtl/crc_standby_fsm.sv
// Module: standby sequencer. It enters standby on a sleep request when standby
// is enabled, leaves standby on a wake interrupt, then counts the settle wait.
// Assumes the settle length is loaded by software before the wake arrives.
module crc_standby_fsm
    import crc_pkg::*;
#(
    parameter int              CNT_W        = 8,
    parameter logic [CNT_W-1:0] SETTLE_RESET = CNT_W'(4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             settle_wr,
    input  logic [CNT_W-1:0] settle_wdata,
    input  logic             sleep_req,
    input  logic             wake_irq,
    input  logic             stby_i,
    output logic             running_o,
    output logic             enter_o,
    output logic             apply_o
);

    pm_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_q;

    // Settle length register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         load_q <= SETTLE_RESET;
        else if (settle_wr) load_q <= settle_wdata;
    end

    // Next-state and counter logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_RUN: begin
                if (sleep_req && stby_i) state_d = ST_STBY;
            end
            ST_STBY: begin
                if (wake_irq) begin
                    state_d = ST_SETTLE;
                    cnt_d   = load_q;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) state_d = ST_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and settle counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign running_o = (state_q == ST_RUN);
    assign enter_o   = (state_q == ST_RUN) && sleep_req && stby_i;
    assign apply_o   = (state_q == ST_SETTLE) && (cnt_q == '0);

    // R4: standby is held until a wake interrupt arrives.
    a_r4_hold_standby: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STBY && !wake_irq |=> state_q == ST_STBY);

    // R6: a wake loads the settle counter from the stored length.
    a_r6_wake_loads: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_STBY && wake_irq |=> state_q == ST_SETTLE && cnt_q == $past(load_q));

    // R6: the settle counter steps down by one each cycle until zero.
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SETTLE && cnt_q != '0 |=> state_q == ST_SETTLE && cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/crc_divider.sv
// Module: enable divider. It emits a one-cycle pulse every factor cycles, where
// the factor comes from the division code. A new code is taken only at the
// terminal count. Assumes run_i is low throughout standby and settling.
module crc_divider
    import crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              en_o
);

    logic [DCNT_W-1:0] dcnt_q;

    // Down counter: parked at zero while halted, reloaded at each terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)              dcnt_q <= '0;
        else if (!run_i)         dcnt_q <= '0;
        else if (dcnt_q == '0)   dcnt_q <= DCNT_W'(div_factor(code_i) - 1'b1);
        else                     dcnt_q <= dcnt_q - 1'b1;
    end

    assign en_o = run_i && (dcnt_q == '0);

    // R9: an interval in progress completes without being restarted.
    a_r9_no_short_interval: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && dcnt_q != '0 |=> !run_i || dcnt_q == $past(dcnt_q) - 1'b1);

endmodule

// File: rtl/clk_ratio_ctrl.sv
// Module: top of the peripheral clock ratio controller. It ties together the
// register file, the standby sequencer and the enable divider.
// Assumes the register strobes are single-cycle and already decoded.
module clk_ratio_ctrl
    import crc_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              frq_wr,
    input  logic [5:0]        frq_wdata,
    input  logic              stb_wr,
    input  logic [1:0]        stb_wdata,
    input  logic              settle_wr,
    input  logic [CNT_W-1:0]  settle_wdata,
    input  logic              sleep_req,
    input  logic              wake_irq,
    output logic              pclk_en,
    output logic [2:0]        active_mul,
    output logic [2:0]        active_div,
    output logic [MODE_W-1:0] active_mode,
    output logic              halted
);

    logic   stby, mdchg, running, enter, apply;
    ratio_t active;

    crc_regs #(
        .MODE_W (MODE_W)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_pins     (mode_pins),
        .frq_wr        (frq_wr),
        .frq_wdata     (ratio_t'(frq_wdata)),
        .stb_wr        (stb_wr),
        .stb_wdata     (stb_wdata),
        .enter_i       (enter),
        .apply_i       (apply),
        .stby_o        (stby),
        .mdchg_o       (mdchg),
        .active_o      (active),
        .active_mode_o (active_mode)
    );

    crc_standby_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .settle_wr    (settle_wr),
        .settle_wdata (settle_wdata),
        .sleep_req    (sleep_req),
        .wake_irq     (wake_irq),
        .stby_i       (stby),
        .running_o    (running),
        .enter_o      (enter),
        .apply_o      (apply)
    );

    crc_divider div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running),
        .code_i (active.div),
        .en_o   (pclk_en)
    );

    assign active_mul = active.mul;
    assign active_div = active.div;
    assign halted     = !running;

    // R4: no enable pulse while halted.
    a_r4_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !pclk_en);

    // R10: the first running cycle after a standby exit carries a pulse.
    a_r10_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted) |-> pclk_en);

    // R2: the change-on-wake bit is read from the register file only.
    a_r2_mdchg_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(mdchg));

endmodule

// File: tb/clk_ratio_ctrl_tb_top.sv
module clk_ratio_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_pins = 3'b110;
    logic       frq_wr = 1'b0;
    logic [5:0] frq_wdata = '0;
    logic       stb_wr = 1'b0;
    logic [1:0] stb_wdata = '0;
    logic       settle_wr = 1'b0;
    logic [7:0] settle_wdata = '0;
    logic       sleep_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic       pclk_en, halted;
    logic [2:0] active_mul, active_div, active_mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic live = 1'b0;

    always #4 clk = ~clk;

    clk_ratio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
        .frq_wr(frq_wr), .frq_wdata(frq_wdata),
        .stb_wr(stb_wr), .stb_wdata(stb_wdata),
        .settle_wr(settle_wr), .settle_wdata(settle_wdata),
        .sleep_req(sleep_req), .wake_irq(wake_irq),
        .pclk_en(pclk_en), .active_mul(active_mul), .active_div(active_div),
        .active_mode(active_mode), .halted(halted)
    );

    function automatic int fact(input logic [2:0] c);
        case (c)
            3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
            3'd4: return 6;  3'd5: return 8;  3'd6: return 12; default: return 16;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    int         m_st = 0, m_cnt = 0, m_load = 4, m_dcnt = 0;
    logic       m_stby = 0, m_mdchg = 0;
    logic [2:0] m_div = 3, m_mul = 1, m_mode = 0, p_div = 3, p_mul = 1, p_mode = 0;

    always @(posedge clk) begin
        live <= rst_n;
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0; m_load <= 4; m_dcnt <= 0;
            m_stby <= 0; m_mdchg <= 0;
            m_div <= 3; m_mul <= 1; p_div <= 3; p_mul <= 1;
            m_mode <= mode_pins; p_mode <= mode_pins;
        end else begin
            if (stb_wr) begin m_mdchg <= stb_wdata[1]; m_stby <= stb_wdata[0]; end
            if (settle_wr) m_load <= int'(settle_wdata);
            if (frq_wr) begin p_div <= frq_wdata[2:0]; p_mul <= frq_wdata[5:3]; end
            if (frq_wr && !m_mdchg) begin
                m_div <= frq_wdata[2:0]; m_mul <= frq_wdata[5:3];
            end else if (m_st == 2 && m_cnt == 0) begin
                m_div <= p_div; m_mul <= p_mul;
            end
            if (m_st == 2 && m_cnt == 0) m_mode <= p_mode;
            if (m_st == 0 && sleep_req && m_stby && m_mdchg) p_mode <= mode_pins;
            case (m_st)
                0: if (sleep_req && m_stby) m_st <= 1;
                1: if (wake_irq) begin m_st <= 2; m_cnt <= m_load; end
                default: if (m_cnt == 0) m_st <= 0; else m_cnt <= m_cnt - 1;
            endcase
            if (m_st != 0)       m_dcnt <= 0;
            else if (m_dcnt == 0) m_dcnt <= fact(m_div) - 1;
            else                  m_dcnt <= m_dcnt - 1;
        end
    end

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (live) begin
            chk(pclk_en == (m_st == 0 && m_dcnt == 0), "R8 model pclk_en", pclk_en, (m_st == 0 && m_dcnt == 0));
            chk(halted == (m_st != 0), "R4 model halted", halted, (m_st != 0));
            chk(active_div == m_div && active_mul == m_mul, "R2/R3/R7 model ratio",
                {active_mul, active_div}, {m_mul, m_div});
            chk(active_mode == m_mode, "R5 model mode", active_mode, m_mode);
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic wr_frq(input logic [5:0] d);
        @(negedge clk); frq_wr = 1'b1; frq_wdata = d;
        @(negedge clk); frq_wr = 1'b0;
    endtask

    task automatic wr_stb(input logic [1:0] d);
        @(negedge clk); stb_wr = 1'b1; stb_wdata = d;
        @(negedge clk); stb_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    task automatic wait_pulse();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (pclk_en) return;
        end
    endtask

    task automatic next_gap(output int g);
        g = 0;
        do begin @(negedge clk); g++; end while (!pclk_en && g < 64);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!halted) return;
        end
    endtask

    initial begin
        int g, n;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(active_div == 3'b011, "R1 reset div", active_div, 3);
        chk(active_mul == 3'b001, "R1 reset mul", active_mul, 1);
        chk(active_mode == 3'b110, "R1 reset mode", active_mode, 6);
        chk(!halted, "R1 reset halted", halted, 0);

        // R8: every division code gives its interval
        for (int c = 0; c < 8; c++) begin
            wr_frq({3'b001, 3'(c)});
            chk(active_div == 3'(c), "R2 immediate div", active_div, c);
            wait_pulse(); next_gap(g); next_gap(g);
            chk(g == fact(3'(c)), "R8 interval", g, fact(3'(c)));
        end

        // R9: change from /16 to /1 right at a pulse
        wr_frq(6'b001_111);
        wait_pulse(); next_gap(g);
        frq_wr = 1'b1; frq_wdata = 6'b001_000; g = 0;
        @(negedge clk); g++; frq_wr = 1'b0;
        while (!pclk_en && g < 64) begin @(negedge clk); g++; end
        chk(g == 16, "R9 old interval kept", g, 16);
        next_gap(g);
        chk(g == 1, "R9 new interval", g, 1);

        // R4: sleep ignored with standby disabled; wake ignored while running
        wr_stb(2'b00);
        pulse_sleep();
        chk(!halted, "R4 sleep ignored", halted, 0);
        pulse_wake();
        chk(!halted, "R6 wake ignored", halted, 0);

        // R6 and R10: settle length and first pulse
        @(negedge clk); settle_wr = 1'b1; settle_wdata = 8'd5;
        @(negedge clk); settle_wr = 1'b0;
        wr_stb(2'b01);
        pulse_sleep();
        chk(halted && !pclk_en, "R4 standby entered", {halted, pclk_en}, 2);
        repeat (3) @(negedge clk);
        pulse_wake();
        n = 0;
        while (halted && n < 100) begin n++; @(negedge clk); end
        chk(n == 6, "R6 settle length", n, 6);
        chk(pclk_en, "R10 first pulse", pclk_en, 1);

        // R3, R5, R7: deferred ratio and mode
        wr_stb(2'b11);
        mode_pins = 3'b101;
        wr_frq(6'b010_010);
        chk(active_div == 3'd0 && active_mul == 3'd1, "R3 deferred hold", {active_mul, active_div}, 6'o10);
        pulse_sleep();
        mode_pins = 3'b010;
        repeat (2) @(negedge clk);
        chk(active_mode == 3'b110, "R5 mode held in standby", active_mode, 6);
        pulse_wake();
        wait_run();
        chk(active_div == 3'd2 && active_mul == 3'd2, "R7 pending ratio applied", {active_mul, active_div}, 6'o22);
        chk(active_mode == 3'b101, "R5 mode applied", active_mode, 5);

        wr_stb(2'b01);
        mode_pins = 3'b111;
        pulse_sleep();
        pulse_wake();
        wait_run();
        chk(active_mode == 3'b101, "R5 no capture without deferral", active_mode, 5);

        // Random phase checked by the model each cycle
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            mode_pins    = 3'($urandom);
            frq_wr       = ($urandom % 10) == 0;
            frq_wdata    = 6'($urandom);
            stb_wr       = ($urandom % 20) == 0;
            stb_wdata    = 2'($urandom);
            settle_wr    = ($urandom % 20) == 0;
            settle_wdata = 8'($urandom % 16);
            sleep_req    = ($urandom % 20) == 0;
            wake_irq     = ($urandom % 10) == 0;
        end
        @(negedge clk);
        frq_wr = 0; stb_wr = 0; settle_wr = 0; sleep_req = 0; wake_irq = 0;
        repeat (5) @(negedge clk);
        summary();
    end

endmodule